// File: doc/BRIEF.md
# Key-Guarded Configuration Register Port

This block gives a host access to a bank of 256 byte-wide configuration registers through two byte ports on a small I/O bus. One port selects a register and the other port reads or writes it. Access is guarded by a key. After reset the block ignores everything except one unlock byte written to the select port. Once open, it accepts index and data traffic until a lock byte is written to the select port.

One bit of one register is brought out as a decode enable. Surrounding logic uses it to answer a second, plug-and-play style group of configuration ports. The enable changes only as a result of data-port writes.

Reads have one cycle of latency. The read strobe is sampled on a rising edge, and `io_rdata` shows the result after that edge. `io_rdata` then holds the value until the next decoded read. The register array uses synchronous reads with no reset on its storage, so it can map onto block RAM. A valid bit for each entry gives the reset value of zero.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the block is locked. The current index is 0x00, every register reads as 0x00, `pnp_decode_en` is 0 and `io_rdata` is 0x00.
- R2: While locked, a write to the index port (address 0x0108) changes nothing unless the byte is 0xAA. A write of 0xAA unlocks the block and leaves the index unchanged.
- R3: While unlocked, a write of 0x55 to the index port locks the block. Any other byte written there, 0xAA included, becomes the current index.
- R4: While unlocked, a write to the data port (address 0x0109) stores the byte in the register selected by the current index.
- R5: While locked, a data-port write leaves every register unchanged.
- R6: While locked, a read of either port returns 0xFF.
- R7: While unlocked, a read of the index port returns the current index, and a read of the data port returns the selected register. In both cases the value is on `io_rdata` from the cycle after the strobe until the next decoded read.
- R8: `pnp_decode_en` equals bit 7 of register 0xC1. It is updated in the cycle after each unlocked data-port write and does not change otherwise.
- R9: Decoding compares all 16 address bits. A read or write to any address other than 0x0108 or 0x0109 has no effect on the lock state, the index, the registers or `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_rdata | output | 8 | Read result, valid from the cycle after a read strobe |
| pnp_decode_en | output | 1 | Enable for decoding the secondary configuration ports |

## Verification
The assertions assume that a read strobe and a write strobe never fall in the same cycle. A same-cycle read and write of one register would otherwise return the old contents. The bench drives each access as a single strobe cycle followed by an idle cycle, so both the write result and the read latency can be seen at the ports. The register sweep skips index 0x55, because that byte locks the block and can never become the index.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;
  typedef enum logic {KEY_LOCKED = 1'b0, KEY_OPEN = 1'b1} key_state_e;
  typedef enum logic [1:0] {SRC_RESET, SRC_ONES, SRC_INDEX, SRC_ARRAY} rd_src_e;
endpackage

// File: rtl/cfgk_port_decode.sv
module cfgk_port_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEL_PORT = 16'h0108,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0109
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  logic hit_sel, hit_dat;

  always_comb begin
    hit_sel = (io_addr == SEL_PORT);
    hit_dat = (io_addr == DAT_PORT);
    sel_wr  = hit_sel & io_wr;
    sel_rd  = hit_sel & io_rd;
    dat_wr  = hit_dat & io_wr;
    dat_rd  = hit_dat & io_rd;
  end
endmodule

// File: rtl/cfgk_key_fsm.sv
module cfgk_key_fsm
  import cfgk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPEN_KEY = 8'hAA,
  parameter logic [DATA_W-1:0] SHUT_KEY = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic [DATA_W-1:0] index
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KEY_LOCKED;
      index   <= '0;
    end else if (sel_wr) begin
      unique case (state_q)
        KEY_LOCKED: if (wdata == OPEN_KEY) state_q <= KEY_OPEN;
        KEY_OPEN: begin
          if (wdata == SHUT_KEY) state_q <= KEY_LOCKED;
          else                   index   <= wdata;
        end
        default: state_q <= KEY_LOCKED;
      endcase
    end
  end

  assign locked = (state_q == KEY_LOCKED);

  p_stay_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && !(sel_wr && wdata == OPEN_KEY)) |=> (locked && $stable(index)));
  p_shut_key_r3: assert property (@(posedge clk) disable iff (rst)
    (!locked && sel_wr && wdata == SHUT_KEY) |=> (locked && $stable(index)));
  p_index_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!locked && sel_wr && wdata != SHUT_KEY) |=> (!locked && index == $past(wdata)));
endmodule

// File: rtl/cfgk_regfile.sv
module cfgk_regfile #(
  parameter int DATA_W   = 8,
  parameter int GATE_REG = 8'hC1,
  parameter int GATE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              gate
);
  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] mem_q;
  logic              vld_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[index] <= wdata;
    if (re) mem_q <= mem[index];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
      gate  <= 1'b0;
    end else begin
      if (we) begin
        vld[index] <= 1'b1;
        if (index == DATA_W'(GATE_REG)) gate <= wdata[GATE_BIT];
      end
      if (re) vld_q <= vld[index];
    end
  end

  assign rdata = vld_q ? mem_q : '0;

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(we && index == DATA_W'(GATE_REG)) |=> $stable(gate));
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata) || $past(rst));
endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
  import cfgk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SEL_PORT = 16'h0108,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0109,
  parameter logic [DATA_W-1:0] OPEN_KEY = 8'hAA,
  parameter logic [DATA_W-1:0] SHUT_KEY = 8'h55,
  parameter int GATE_REG = 8'hC1,
  parameter int GATE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              pnp_decode_en
);
  logic sel_wr, sel_rd, dat_wr, dat_rd;
  logic locked;
  logic [DATA_W-1:0] index, arr_rdata, idx_cap;
  rd_src_e src_q;

  cfgk_port_decode #(.ADDR_W(ADDR_W), .SEL_PORT(SEL_PORT), .DAT_PORT(DAT_PORT)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .sel_wr(sel_wr), .sel_rd(sel_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  cfgk_key_fsm #(.DATA_W(DATA_W), .OPEN_KEY(OPEN_KEY), .SHUT_KEY(SHUT_KEY)) u_key (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .wdata(io_wdata),
    .locked(locked), .index(index)
  );

  cfgk_regfile #(.DATA_W(DATA_W), .GATE_REG(GATE_REG), .GATE_BIT(GATE_BIT)) u_regs (
    .clk(clk), .rst(rst),
    .we(dat_wr && !locked), .re(dat_rd && !locked),
    .index(index), .wdata(io_wdata),
    .rdata(arr_rdata), .gate(pnp_decode_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= SRC_RESET;
      idx_cap <= '0;
    end else if (sel_rd || dat_rd) begin
      if (locked)      src_q <= SRC_ONES;
      else if (sel_rd) src_q <= SRC_INDEX;
      else             src_q <= SRC_ARRAY;
      idx_cap <= index;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ONES:  io_rdata = '1;
      SRC_INDEX: io_rdata = idx_cap;
      SRC_ARRAY: io_rdata = arr_rdata;
      default:   io_rdata = '0;
    endcase
  end

  p_locked_read_r6: assert property (@(posedge clk) disable iff (rst)
    ((sel_rd || dat_rd) && locked) |=> io_rdata == '1);
  p_index_read_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_rd && !locked) |=> io_rdata == $past(index));
  p_no_decode_r9: assert property (@(posedge clk) disable iff (rst)
    (!(sel_rd || dat_rd || sel_wr || dat_wr) && !$past(rst)) |=> $stable(io_rdata));
endmodule

// File: tb/cfg_keyed_port_tb_top.sv
`timescale 1ns/1ps
module cfg_keyed_port_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic pnp_decode_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  cfg_keyed_port dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .pnp_decode_en(pnp_decode_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  // result is on io_rdata at the negedge after the strobe edge
  task automatic io_read(input logic [15:0] a, input string req, input logic [7:0] exp);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    check(req, io_rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", io_rdata, 8'h00);
    check("R1 gate", {7'd0, pnp_decode_en}, 8'h00);
    io_read(16'h0108, "R6 locked index read", 8'hFF);
    io_read(16'h0109, "R6 locked data read", 8'hFF);
    // R2 non-key writes while locked are ignored
    io_write(16'h0108, 8'h12);
    io_write(16'h0109, 8'h34);
    io_read(16'h0109, "R2 still locked", 8'hFF);
    io_write(16'h0108, 8'hAA);
    io_read(16'h0108, "R1 index zero after unlock", 8'h00);
    io_read(16'h0109, "R1 reg0 zero", 8'h00);
    io_read(16'h0109, "R5 locked data write ignored", 8'h00);
    // R4 sweep of all reachable registers
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    for (int i = 0; i < 256; i++) begin
      if (i == 8'h55) continue;
      io_write(16'h0108, 8'(i));
      io_write(16'h0109, 8'((i * 37 + 11) & 255));
      model[i] = 8'((i * 37 + 11) & 255);
      if (i == 8'hC1) begin
        @(negedge clk);
        check("R8 gate follows bit7", {7'd0, pnp_decode_en}, {7'd0, model[8'hC1][7]});
      end
    end
    for (int i = 0; i < 256; i++) begin
      if (i == 8'h55) continue;
      io_write(16'h0108, 8'(i));
      io_read(16'h0108, "R7 index readback", 8'(i));
      io_read(16'h0109, "R4 data readback", model[i]);
    end
    // R8 clear then set the gate bit, other writes keep it
    io_write(16'h0108, 8'hC1);
    io_write(16'h0109, 8'h7F);
    check("R8 gate cleared", {7'd0, pnp_decode_en}, 8'h00);
    io_write(16'h0109, 8'h80);
    check("R8 gate set", {7'd0, pnp_decode_en}, 8'h01);
    io_write(16'h0108, 8'h20);
    io_write(16'h0109, 8'h00);
    check("R8 gate kept on other write", {7'd0, pnp_decode_en}, 8'h01);
    // R3 0xAA while open is an index; 0x55 locks
    io_write(16'h0108, 8'hAA);
    io_read(16'h0108, "R3 AA as index", 8'hAA);
    io_write(16'h0108, 8'h30);
    io_write(16'h0108, 8'h55);
    io_read(16'h0108, "R3 locked by key", 8'hFF);
    // R5 locked writes do not touch the array or the gate
    io_write(16'h0109, 8'hE7);
    io_write(16'h0108, 8'hC1);
    io_write(16'h0109, 8'h00);
    check("R5 gate kept while locked", {7'd0, pnp_decode_en}, 8'h01);
    io_write(16'h0108, 8'hAA);
    io_read(16'h0108, "R2 index kept across lock", 8'h30);
    io_read(16'h0109, "R5 reg unchanged", model[8'h30]);
    // R9 full address decode
    io_write(16'h1108, 8'h40);
    io_write(16'h8109, 8'h99);
    io_read(16'h0508, "R9 foreign read holds rdata", model[8'h30]);
    io_read(16'h0108, "R9 index untouched", 8'h30);
    io_read(16'h0109, "R9 reg untouched", model[8'h30]);
    io_write(16'h0109, 8'h5A);
    repeat (3) @(negedge clk);
    check("R7 rdata holds without read", io_rdata, model[8'h30]);
    io_read(16'h0109, "R4 overwrite", 8'h5A);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule